// File: doc/BRIEF.md
# Prioritized Hardware Interrupt Controller

This block gathers sixteen external interrupt lines for a small 16-bit core. Each line is watched for a low-to-high transition; a transition latches a pending bit that stays set until software acknowledges it. A per-line enable register decides which pending bits may raise an interrupt. Among the lines that are both pending and enabled, the one with the lowest index wins. The block then presents the matching interrupt number and the address of its vector-table slot to the core.

The core owns the global interrupt-enable bit and feeds it in. When the core accepts `irq_req` it stacks its own state and clears that bit; that work lies outside this block. Software changes the enable and pending registers through three strobes that share one 16-bit bitmask operand. A wait strobe stalls the core until an enabled pending line exists. Waking does not depend on the global enable, so a core that sleeps with interrupts off can still poll.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `pend_status` is 0, every line is disabled, and `irq_req`, `wake` and `core_halt` are 0.
- R2: A 0-to-1 transition on `irq_lines[n]`, seen at a clock edge against the value sampled at the previous edge, sets `pend_status[n]` from the following cycle on. A line that stays high sets nothing more. A line already high when reset is released counts as a transition.
- R3: With `unmask_cmd` high, the lines whose `cmd_bits` are 1 become enabled. With `mask_cmd` high, they become disabled. If both strobes are high in the same cycle, those lines end up disabled.
- R4: With `ack_cmd` high, the pending bits selected by `cmd_bits` are cleared. A new transition on a line in that same cycle leaves its bit set.
- R5: The selected line is the lowest index n with both pending and enabled set. `irq_num` is 0x70 + n, a 7-bit value.
- R6: `vec_addr` is 0xFF00 + 2 × `irq_num`.
- R7: `irq_req` is 1 exactly when `int_en` is 1 and at least one line is pending and enabled.
- R8: `wake` is 1 exactly when at least one line is pending and enabled, whatever the value of `int_en`. Pending lines that are disabled do not wake the core.
- R9: A `wait_req` pulse with no enabled pending line makes `core_halt` 1 from the next cycle on. `core_halt` falls in the same cycle that `wake` rises, and the wait state ends there. A `wait_req` while `wake` is already 1 does not halt the core.
- R10: `pend_status` shows all pending bits, including those of disabled lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 16 | External interrupt lines, edge detected |
| int_en | input | 1 | Global interrupt-enable bit from the core |
| mask_cmd | input | 1 | Disable the lines selected by cmd_bits |
| unmask_cmd | input | 1 | Enable the lines selected by cmd_bits |
| ack_cmd | input | 1 | Clear the pending bits selected by cmd_bits |
| cmd_bits | input | 16 | Bitmask operand shared by the three strobes |
| wait_req | input | 1 | Request to stall the core until an interrupt |
| pend_status | output | 16 | Pending bits, for status reads |
| irq_req | output | 1 | Interrupt request to the core |
| irq_num | output | 7 | Interrupt number of the selected line |
| vec_addr | output | 16 | Vector-table address for irq_num |
| wake | output | 1 | An enabled line is pending |
| core_halt | output | 1 | Core must stall, waiting for an interrupt |

## Verification
Two pairs of events can land on the same clock edge. The first is an acknowledge and a fresh edge on the same line; the second is a mask and an unmask of the same line. The bench drives each pair together on one edge and then reads `pend_status` and `wake` to confirm that the edge survives and that the mask wins. A third case is a wait request while an enabled line is already pending; there the bench checks that `core_halt` never rises. The priority encoder gets a walking sweep of lines and then a few hundred pseudo-random pairs of line pattern and enable mask, each with its lowest set index computed in the bench.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int          N        = 16,
  parameter int          NUM_W    = 7,
  parameter int          ADDR_W   = 16,
  parameter logic [6:0]  NUM_BASE = 7'h70,
  parameter logic [15:0] VEC_BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_lines,
  input  logic              int_en,
  input  logic              mask_cmd,
  input  logic              unmask_cmd,
  input  logic              ack_cmd,
  input  logic [N-1:0]      cmd_bits,
  input  logic              wait_req,
  output logic [N-1:0]      pend_status,
  output logic              irq_req,
  output logic [NUM_W-1:0]  irq_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              wake,
  output logic              core_halt
);
  localparam int IW = $clog2(N);

  logic [N-1:0] lines_q, pend, en_mask, live, rise;
  logic [IW-1:0] sel_idx;
  logic sleeping;

  assign rise = irq_lines & ~lines_q;
  assign live = pend & en_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lines_q  <= '0;
      pend     <= '0;
      en_mask  <= '0;
      sleeping <= 1'b0;
    end else begin
      lines_q <= irq_lines;
      pend    <= (pend & ~(ack_cmd ? cmd_bits : '0)) | rise;
      if (mask_cmd)
        en_mask <= (en_mask | (unmask_cmd ? cmd_bits : '0)) & ~cmd_bits;
      else if (unmask_cmd)
        en_mask <= en_mask | cmd_bits;
      if (wake)
        sleeping <= 1'b0;
      else if (wait_req)
        sleeping <= 1'b1;
    end
  end

  always_comb begin
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (live[i]) sel_idx = IW'(i);
  end

  assign wake        = |live;
  assign irq_req     = wake & int_en;
  assign irq_num     = NUM_BASE + NUM_W'(sel_idx);
  assign vec_addr    = VEC_BASE + (ADDR_W'(irq_num) << 1);
  assign core_halt   = sleeping & ~wake;
  assign pend_status = pend;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] irq_lines,
  input logic        int_en,
  input logic        mask_cmd,
  input logic        ack_cmd,
  input logic [15:0] cmd_bits,
  input logic [15:0] pend_status,
  input logic [15:0] en_mask,
  input logic        irq_req,
  input logic [6:0]  irq_num,
  input logic        wake,
  input logic        core_halt
);
  AST_REQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int_en && wake)); // R7

  AST_WAKE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((pend_status & en_mask) != 16'h0)); // R8

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_cmd |=> ((pend_status & $past(cmd_bits) & ~$past(irq_lines)) == 16'h0)); // R4

  AST_MASK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_cmd |=> ((en_mask & $past(cmd_bits)) == 16'h0)); // R3

  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_status[irq_num[3:0]] && en_mask[irq_num[3:0]] &&
      ((pend_status & en_mask & ((16'd1 << irq_num[3:0]) - 16'd1)) == 16'h0))); // R5

  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_num[6:4] == 3'b111)); // R5

  AST_NO_HALT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    core_halt |-> !wake); // R9
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_en(int_en),
  .mask_cmd(mask_cmd), .ack_cmd(ack_cmd), .cmd_bits(cmd_bits),
  .pend_status(pend_status), .en_mask(en_mask), .irq_req(irq_req),
  .irq_num(irq_num), .wake(wake), .core_halt(core_halt)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] irq_lines = '0, cmd_bits = '0;
  logic int_en = 1'b0, mask_cmd = 1'b0, unmask_cmd = 1'b0, ack_cmd = 1'b0, wait_req = 1'b0;
  logic [15:0] pend_status, vec_addr;
  logic [6:0] irq_num;
  logic irq_req, wake, core_halt;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  irq_prio_ctrl dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
    mask_cmd = 0; unmask_cmd = 0; ack_cmd = 0; wait_req = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmd(logic m, logic u, logic a, logic [15:0] b);
    mask_cmd = m; unmask_cmd = u; ack_cmd = a; cmd_bits = b;
    step();
  endtask

  function automatic int lowest(logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = 0;
  endfunction

  initial begin
    logic [15:0] lf = 16'hACE1, pat, msk, lv;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    chk("R1 pend", pend_status, 0);
    chk("R1 req", irq_req, 0);
    chk("R1 wake", wake, 0);
    chk("R1 halt", core_halt, 0);

    int_en = 1; irq_lines = 16'h0008; step();
    chk("R2 rise", pend_status, 16'h0008);
    chk("R10 masked pending visible", pend_status[3], 1);
    chk("R8 masked no wake", wake, 0);
    chk("R7 masked no req", irq_req, 0);

    cmd(0, 1, 0, 16'h0008);
    chk("R3 unmask wake", wake, 1);
    chk("R7 req", irq_req, 1);
    chk("R5 num", irq_num, 7'h73);
    chk("R6 vec", vec_addr, 16'hFFE6);
    int_en = 0; #1;
    chk("R7 ien off", irq_req, 0);
    chk("R8 wake without ien", wake, 1);
    int_en = 1;

    cmd(0, 0, 1, 16'h0008);
    chk("R4 ack", pend_status, 0);
    step();
    chk("R2 level no retrigger", pend_status, 0);
    irq_lines = 0; step();
    irq_lines = 16'h0008; cmd(0, 0, 1, 16'h0008);
    chk("R4 edge beats ack", pend_status, 16'h0008);

    cmd(1, 1, 0, 16'h0008);
    chk("R3 mask wins", wake, 0);
    chk("R10 pend kept", pend_status, 16'h0008);
    cmd(0, 1, 0, 16'h0008);
    chk("R3 reenable", wake, 1);
    cmd(1, 0, 0, 16'h0008);
    chk("R3 mask", wake, 0);

    irq_lines = 0; cmd(0, 1, 1, 16'hFFFF);
    chk("R4 ack all", pend_status, 0);
    wait_req = 1; step();
    chk("R9 halt", core_halt, 1);
    step();
    chk("R9 halt held", core_halt, 1);
    irq_lines = 16'h0020; step();
    chk("R9 wake", wake, 1);
    chk("R9 halt drops", core_halt, 0);
    cmd(0, 0, 1, 16'h0020);
    chk("R9 wait ended", core_halt, 0);
    irq_lines = 16'h0040; step();
    wait_req = 1; step();
    chk("R9 wait while awake", core_halt, 0);
    cmd(0, 0, 1, 16'hFFFF);
    chk("R9 no stale sleep", core_halt, 0);

    for (int n = 0; n < 16; n++) begin
      irq_lines = 0; cmd(0, 0, 1, 16'hFFFF);
      irq_lines = 16'hFFFF << n; step();
      chk("R5 walk num", irq_num, 32'h70 + n);
      chk("R6 walk vec", vec_addr, 32'hFF00 + 2 * (32'h70 + n));
      chk("R7 walk req", irq_req, 1);
    end

    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; pat = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; msk = lf;
      int_en = k[0];
      irq_lines = 0; cmd(1, 0, 1, 16'hFFFF);
      cmd(0, 1, 0, msk);
      irq_lines = pat; step();
      lv = pat & msk;
      chk("R10 sweep pend", pend_status, pat);
      chk("R8 sweep wake", wake, lv != 0);
      chk("R7 sweep req", irq_req, (lv != 0) && int_en);
      if (lv != 0) chk("R5 sweep num", irq_num, 32'h70 + lowest(lv));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule